// File: doc/BRIEF.md
# Two-Step Half-Flash Conversion Sequencer

This block is the digital sequencer of a 10-bit two-step flash converter. A coarse estimator of seven comparators, with thresholds at 1/16, 3/16, 5/16, 7/16, 9/16, 11/16 and 13/16 of full scale, places the input in one of eight coarse regions. The sequencer turns that estimate into the base of a window of sixteen taps on a 64-step MSB ladder. The window is routed to a single bank of sixteen comparators, and their thermometer output gives the six upper bits.

The same comparator bank is then switched to the residue path. It compares the input, minus the MSB tap just below it, against sixteen taps of 1/1024 full scale. This gives the four lower bits, and the whole 10-bit code is stored in one register. The selected window extends one sixteenth of full scale past the estimated region on each side, so a moderate estimator error still yields the correct code.

A conversion is started by a one-cycle strobe while the sequencer is idle. It then takes one clock for each of the estimate, coarse, fine and latch phases, and a done pulse marks the latch phase. The analog ladders and comparators are outside the block.

Top module: `hfc_twostep_ctrl`

## Requirements
- R1: While reset is held, and after it is released, tap_sel_o is 0, fine_sel_o is 0, result_o is 0 and done_o is 0.
- R2: A start_i seen high at a rising edge in the idle state begins a conversion. done_o is high for exactly the one cycle that follows the fourth rising edge counted from that edge, and is low otherwise.
- R3: est_therm_i is sampled at the first edge after the start edge. Bit t of est_therm_i is the comparator with threshold (2t+1)/16 of full scale. With c equal to the number of ones, the window base is 8c-8 in 1/64 units, clamped to 0..48. The base is shown on tap_sel_o with fine_sel_o low during the coarse cycle. Comparator i of cmp_therm_i then compares against MSB tap base+i+1.
- R4: The six-bit MSB value is the window base plus the number of ones in cmp_therm_i sampled in the coarse cycle, saturated at 63.
- R5: In the cycle after the coarse cycle, fine_sel_o is 1 (residue path) and tap_sel_o carries the MSB value. In that cycle comparator i compares the residue against i+1 LSB steps.
- R6: The four-bit LSB value is the number of ones in cmp_therm_i sampled in the fine cycle, saturated at 15.
- R7: result_o equals {MSB, LSB} from the done cycle onward. It changes only at the edge that ends the fine cycle and otherwise holds its value.
- R8: A thermometer code with bubbles, from the estimator or from the bank, is resolved by counting its ones, so moving a 1 to a position above a 0 does not change the result.
- R9: start_i is ignored in every state except idle. A start held across a conversion launches no second conversion until the idle cycle that follows the done cycle.
- R10: If every estimator threshold is shifted by the same amount, up to 1/16 of full scale in either direction, the 10-bit result still equals the ideal code of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion start strobe |
| est_therm_i | input | N_EST (7) | Coarse estimator thermometer code |
| cmp_therm_i | input | N_CMP (16) | Shared comparator bank thermometer code |
| tap_sel_o | output | MSB_W (6) | Window base (coarse) or MSB tap (fine), in 1/64 units |
| fine_sel_o | output | 1 | 0: bank on MSB ladder window, 1: bank on residue path |
| result_o | output | MSB_W+LSB_W (10) | Latched conversion code |
| done_o | output | 1 | One-cycle pulse in the latch cycle |

## Verification
The done cycle and the acceptance of a new start are neighbours. A start held high through the latch cycle must be ignored, and the very next idle cycle must accept it. The bench holds start_i high for fifteen cycles and expects done pulses exactly five cycles apart, each with the correct code. It also holds the strobe through one full conversion, including the latch edge, and then drops it, expecting a single pulse. A second overlap arises when the coarse sum and the saturation limit meet: a forced all-ones bank on the top window must give 63, not a wrapped value.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

   // Conversion phases, one clock each
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_EST    = 3'd1,
      ST_COARSE = 3'd2,
      ST_FINE   = 3'd3,
      ST_LATCH  = 3'd4
   } hfc_state_e;

endpackage

// File: rtl/hfc_ones_count.sv
// Counts the ones of a thermometer code; bubbles cost nothing extra.
module hfc_ones_count #(
   parameter int W  = 16,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  therm_i,
   output logic [CW-1:0] ones_o
);

   if (CW < $clog2(W + 1)) begin : g_bad_cw
      $error("hfc_ones_count: CW too narrow for W");
   end

   logic [CW-1:0] lane [W];

   for (genvar g = 0; g < W; g++) begin : g_lane
      assign lane[g] = CW'(therm_i[g]);
   end

   always_comb begin
      ones_o = '0;
      for (int i = 0; i < W; i++) begin
         ones_o = ones_o + lane[i];
      end
   end

endmodule

// File: rtl/hfc_window.sv
// Maps the estimator count to the base tap of the comparator window.
module hfc_window #(
   parameter int N_EST = 7,
   parameter int MSB_W = 6,
   parameter int N_CMP = 16
) (
   input  logic [N_EST-1:0] est_therm_i,
   output logic [MSB_W-1:0] base_o
);

   localparam int REGIONS  = N_EST + 1;
   localparam int STEP     = (1 << MSB_W) / REGIONS;
   localparam int MAX_BASE = (1 << MSB_W) - N_CMP;
   localparam int ECW      = $clog2(N_EST + 1);

   if (((1 << MSB_W) % REGIONS) != 0) begin : g_bad_regions
      $error("hfc_window: ladder not divisible into estimator regions");
   end
   if (N_CMP < 2 * STEP) begin : g_bad_span
      $error("hfc_window: window cannot cover region plus margins");
   end

   logic [ECW-1:0] region;
   int             raw;

   hfc_ones_count #(.W(N_EST), .CW(ECW)) u_est_cnt (
      .therm_i (est_therm_i),
      .ones_o  (region)
   );

   // base = STEP*region - STEP, held inside the ladder
   always_comb begin
      raw = STEP * int'(region) - STEP;
      if (raw < 0)
         base_o = '0;
      else if (raw > MAX_BASE)
         base_o = MSB_W'(MAX_BASE);
      else
         base_o = MSB_W'(raw);
   end

endmodule

// File: rtl/hfc_seq.sv
// Phase sequencer: idle, estimate, coarse, fine, latch.
module hfc_seq
   import hfc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   output hfc_state_e state_o
);

   hfc_state_e nxt;

   always_comb begin
      case (state_o)
         ST_IDLE:   nxt = start_i ? ST_EST : ST_IDLE;
         ST_EST:    nxt = ST_COARSE;
         ST_COARSE: nxt = ST_FINE;
         ST_FINE:   nxt = ST_LATCH;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o <= ST_IDLE;
      else        state_o <= nxt;
   end

endmodule

// File: rtl/hfc_twostep_ctrl.sv
module hfc_twostep_ctrl
   import hfc_pkg::*;
#(
   parameter int MSB_W = 6,
   parameter int LSB_W = 4,
   parameter int N_EST = 7,
   parameter int N_CMP = 1 << LSB_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [N_EST-1:0]       est_therm_i,
   input  logic [N_CMP-1:0]       cmp_therm_i,
   output logic [MSB_W-1:0]       tap_sel_o,
   output logic                   fine_sel_o,
   output logic [MSB_W+LSB_W-1:0] result_o,
   output logic                   done_o
);

   localparam int RES_W    = MSB_W + LSB_W;
   localparam int CCW      = $clog2(N_CMP + 1);
   localparam int SUM_W    = MSB_W + 2;
   localparam int MSB_MAX  = (1 << MSB_W) - 1;
   localparam int LSB_MAX  = (1 << LSB_W) - 1;

   if (N_CMP != (1 << LSB_W)) begin : g_bad_bank
      $error("hfc_twostep_ctrl: bank size must equal LSB ladder steps");
   end
   if (N_CMP > (1 << MSB_W)) begin : g_bad_ladder
      $error("hfc_twostep_ctrl: bank larger than MSB ladder");
   end

   hfc_state_e         state;
   logic [MSB_W-1:0]   base_w;
   logic [CCW-1:0]     cmp_cnt;
   logic [MSB_W-1:0]   base_q;
   logic [MSB_W-1:0]   msb_q;
   logic [RES_W-1:0]   result_q;
   logic [SUM_W-1:0]   msb_sum;
   logic [MSB_W-1:0]   msb_nxt;
   logic [LSB_W-1:0]   lsb_nxt;

   hfc_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .state_o (state)
   );

   hfc_window #(.N_EST(N_EST), .MSB_W(MSB_W), .N_CMP(N_CMP)) u_win (
      .est_therm_i (est_therm_i),
      .base_o      (base_w)
   );

   // one counter serves both flashes of the shared bank
   hfc_ones_count #(.W(N_CMP), .CW(CCW)) u_cmp_cnt (
      .therm_i (cmp_therm_i),
      .ones_o  (cmp_cnt)
   );

   assign msb_sum = SUM_W'(base_q) + SUM_W'(cmp_cnt);
   assign msb_nxt = (msb_sum > SUM_W'(MSB_MAX)) ? '1 : msb_sum[MSB_W-1:0];
   assign lsb_nxt = (cmp_cnt > CCW'(LSB_MAX))   ? '1 : cmp_cnt[LSB_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         msb_q    <= '0;
         result_q <= '0;
      end else begin
         if (state == ST_EST)    base_q   <= base_w;
         if (state == ST_COARSE) msb_q    <= msb_nxt;
         if (state == ST_FINE)   result_q <= {msb_q, lsb_nxt};
      end
   end

   assign fine_sel_o = (state == ST_FINE);
   assign tap_sel_o  = fine_sel_o ? msb_q : base_q;
   assign result_o   = result_q;
   assign done_o     = (state == ST_LATCH);

endmodule

// File: rtl/hfc_twostep_chk.sv
module hfc_twostep_chk #(
   parameter int MSB_W = 6,
   parameter int LSB_W = 4,
   parameter int N_EST = 7,
   parameter int N_CMP = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [MSB_W-1:0]       tap_sel_o,
   input logic                   fine_sel_o,
   input logic [MSB_W+LSB_W-1:0] result_o,
   input logic                   done_o
);

   localparam int RES_W    = MSB_W + LSB_W;
   localparam int STEP     = (1 << MSB_W) / (N_EST + 1);
   localparam int MAX_BASE = (1 << MSB_W) - N_CMP;

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R5
   fine_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fine_sel_o |=> (!fine_sel_o && done_o));

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fine_sel_o |=> $stable(result_o));

   // R4
   msb_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (result_o[RES_W-1:LSB_W] == $past(tap_sel_o)));

   // R4
   msb_above_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fine_sel_o |-> (tap_sel_o >= $past(tap_sel_o)));

   // R3
   base_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fine_sel_o |-> ((int'(tap_sel_o) <= MAX_BASE) && ((int'(tap_sel_o) % STEP) == 0)));

endmodule

bind hfc_twostep_ctrl hfc_twostep_chk #(
   .MSB_W (MSB_W),
   .LSB_W (LSB_W),
   .N_EST (N_EST),
   .N_CMP (N_CMP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tap_sel_o  (tap_sel_o),
   .fine_sel_o (fine_sel_o),
   .result_o   (result_o),
   .done_o     (done_o)
);

// File: tb/sim_hfc_twostep_ctrl.sv
module sim_hfc_twostep_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [6:0]  est;
   logic [15:0] cmp;
   logic [5:0]  tap;
   logic        fine;
   logic [9:0]  result;
   logic        done;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // behavioural analog model
   int          vin = 0;
   int          est_off = 0;
   logic [6:0]  bub_e = '0;
   logic [15:0] bub_c = '0;
   logic [15:0] bub_f = '0;
   logic        force_c = 1'b0;
   logic        force_f = 1'b0;

   always #2.5 clk = ~clk;

   hfc_twostep_ctrl u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .est_therm_i (est),
      .cmp_therm_i (cmp),
      .tap_sel_o   (tap),
      .fine_sel_o  (fine),
      .result_o    (result),
      .done_o      (done)
   );

   always_comb begin
      est = '0;
      for (int t = 0; t < 7; t++) est[t] = (vin >= (2 * t + 1) * 64 + est_off);
      est = est ^ bub_e;
      cmp = '0;
      for (int i = 0; i < 16; i++) begin
         if (!fine) cmp[i] = (vin >= (int'(tap) + i + 1) * 16);
         else       cmp[i] = ((vin - int'(tap) * 16) >= i + 1);
      end
      if (!fine) cmp = (cmp ^ bub_c) | {16{force_c}};
      else       cmp = (cmp ^ bub_f) | {16{force_f}};
   end

   localparam int N_VEC = 16;
   localparam int TV_VIN  [N_VEC] = '{0, 15, 64, 191, 192, 511, 512, 700,
                                      1023, 127, 128, 959, 830, 400, 895, 255};
   localparam int TV_OFF  [N_VEC] = '{0, 0, 0, 0, 0, 0, 0, 0,
                                      0, 64, -64, 64, -64, 40, -60, 64};
   localparam int TV_BASE [N_VEC] = '{0, 0, 0, 0, 8, 24, 24, 32,
                                      48, 0, 8, 48, 48, 16, 48, 0};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // one conversion; samples at falling edges after each rising edge
   task automatic convert(input int v, input int off, input int exp_base,
                          input int exp_msb, input int exp_code, input string tag);
      vin = v;
      est_off = off;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;                 // estimate cycle
      chk(done == 1'b0, {"R2 ", tag}, int'(done), 0);
      @(negedge clk);                              // coarse cycle
      chk(fine == 1'b0 && int'(tap) == exp_base, {"R3 ", tag}, int'(tap), exp_base);
      @(negedge clk);                              // fine cycle
      chk(fine == 1'b1 && int'(tap) == exp_msb, {"R5 R4 ", tag}, int'(tap), exp_msb);
      @(negedge clk);                              // latch cycle
      chk(done == 1'b1 && int'(result) == exp_code, {"R7 R6 ", tag}, int'(result), exp_code);
      @(negedge clk);                              // back to idle
      chk(done == 1'b0 && int'(result) == exp_code, {"R2 R7 ", tag}, int'(result), exp_code);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin : main
      int dones;
      int last_done;
      bit gap_ok;

      // R1: reset state, during and after reset
      repeat (3) @(negedge clk);
      chk(tap == 0 && fine == 0 && result == 0 && done == 0, "R1", int'(result), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(tap == 0 && fine == 0 && result == 0 && done == 0, "R1", int'(tap), 0);

      // vector table: ideal and shifted estimator (R3 R4 R5 R6 R7 R10)
      for (int n = 0; n < N_VEC; n++) begin
         convert(TV_VIN[n], TV_OFF[n], TV_BASE[n], TV_VIN[n] / 16, TV_VIN[n],
                 (TV_OFF[n] != 0) ? "R10" : "R6");
      end

      // R7: result holds through idle cycles
      repeat (5) @(negedge clk);
      chk(int'(result) == 255 && done == 1'b0, "R7 hold", int'(result), 255);

      // R4: coarse bank all ones on top window saturates MSB at 63
      force_c = 1'b1;
      convert(900, 0, 48, 63, 1008, "R4 sat");
      force_c = 1'b0;

      // R6: fine bank all ones saturates LSB at 15
      force_f = 1'b1;
      convert(0, 0, 0, 0, 15, "R6 sat");
      force_f = 1'b0;

      // R8: bubbles in estimator, coarse and fine codes
      bub_e = 7'b0000110;
      bub_c = 16'h0A00;
      bub_f = 16'h2800;
      convert(300, 0, 8, 18, 300, "R8 bubble");
      bub_e = '0;
      bub_c = '0;
      bub_f = '0;

      // R9: start held through a full conversion and its latch edge
      vin = 517;
      est_off = 0;
      dones = 0;
      last_done = -1;
      @(negedge clk) start = 1'b1;
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         if (done) begin dones++; last_done = k; end
      end
      start = 1'b0;
      for (int k = 6; k <= 11; k++) begin
         @(negedge clk);
         if (done) dones++;
      end
      chk(dones == 1, "R9 single", dones, 1);
      chk(last_done == 4 && int'(result) == 517, "R9 timing", last_done, 4);

      // R9 R2: continuous start gives done every five cycles
      vin = 777;
      dones = 0;
      last_done = -1;
      gap_ok = 1'b1;
      @(negedge clk) start = 1'b1;
      for (int k = 1; k <= 15; k++) begin
         @(negedge clk);
         if (done) begin
            dones++;
            if (int'(result) != 777) gap_ok = 1'b0;
            if (last_done >= 0 && k - last_done != 5) gap_ok = 1'b0;
            if (last_done < 0 && k != 4) gap_ok = 1'b0;
            last_done = k;
         end
      end
      start = 1'b0;
      chk(dones == 3, "R9 back-to-back count", dones, 3);
      chk(gap_ok, "R2 R9 back-to-back spacing", int'(gap_ok), 1);
      repeat (6) @(negedge clk);
      chk(done == 1'b0 && fine == 1'b0, "R9 quiet", int'(done), 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule